// File: doc/BRIEF.md
# Compact 16-bit Sequencer Core

This block is a small multi-cycle processor for a low-power domain. It reads 32-bit instruction words from one word-addressed memory port and writes and reads data words through the same port. The program counter is 11 bits wide. The core has four 16-bit working registers (r0 to r3), a zero flag, an overflow flag and an 8-bit stage counter that is kept apart from the working registers. It runs ALU operations and branches of three kinds: absolute, relative on r0 and relative on the stage counter. It also runs an indirect load, an indirect store, a timed stall and a halt. The core never writes an instruction word.

After reset the core sits idle and drives `halted` high. A one-cycle `run` pulse loads the program counter from `start_addr` and starts execution. The core runs until it executes a halt. Then it waits for the next pulse. Any other major opcode is a one-cycle no-op that only advances the program counter.

The control is one state machine. The states are `ST_IDLE`, `ST_FETCH`, `ST_LATCH`, `ST_EXEC`, `ST_LDWAIT` and `ST_DELAY`. Its transitions are:
- IDLE to FETCH on `run`, and IDLE to IDLE otherwise.
- FETCH to LATCH, then LATCH to EXEC.
- EXEC to IDLE on a halt.
- EXEC to LDWAIT on a load.
- EXEC to DELAY on a delay with a non-zero count.
- EXEC to FETCH in every other case.
- LDWAIT to FETCH.
- DELAY to FETCH when the count expires, and DELAY to DELAY otherwise.

Top module: `mc16_core`

## Requirements
- R1: After reset, and at any time the core is idle, `halted` is 1 and both `mem_rd` and `mem_wr` are 0.
- R2: A `run` pulse while the core is idle starts a fetch from `start_addr` in the next cycle. A `run` pulse while the core is not idle has no effect, and this includes the cycle in which a halt executes.
- R3: Opcode 7 (bits [31:28]) is an ALU operation. Sub-opcode [27:25] = 0 is the register form: dest [1:0], A [3:2], B [5:4]. Sub-opcode 1 is the immediate form: B is the immediate [19:4]. Select [24:21] chooses the operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 move, 5 shift left, 6 shift right. The register-form move copies A and the immediate-form move copies the immediate. Results wrap at 16 bits, and a shift by 16 or more gives 0. Each instruction takes three cycles, fetch to fetch.
- R4: Every register-writing ALU operation sets the zero flag to (result == 0). It sets the overflow flag to the carry of an add, the borrow of a subtract, and 0 for any other operation. No other instruction changes either flag.
- R5: Sub-opcode 2 of opcode 7 works on the stage counter. Select 0 adds the immediate [11:4], select 1 subtracts it and select 2 clears the counter. Results wrap at 8 bits.
- R6: Opcode 8 with sub-opcode 0 is an absolute branch. The target is field [12:2] when bit 21 is 0, or the low 11 bits of the register selected by [1:0] when bit 21 is 1. The condition [24:22] is 0 always, 1 zero flag set, or 2 overflow flag set.
- R7: Opcode 8 with sub-opcode 1 compares r0 with the immediate [15:0]. Bit 16 = 0 branches when r0 is less, and bit 16 = 1 branches when r0 is greater or equal. The target is PC ± [23:17], with bit 24 = 1 meaning minus. A branch that is not taken goes to PC+1.
- R8: Opcode 8 with sub-opcode 2 compares the stage counter with the immediate [7:0]. Code [16:15] selects the test: 0 less, 1 greater or equal, 2 less or equal. The offset and the sign are coded as in R7.
- R9: Opcode 6 writes {PC[10:0], 000, address-register index, data} to the address (address register + [20:10]) mod 2048. The address register is selected by [3:2] and the data register by [1:0].
- R10: Opcode 13 reads the word at (register [3:2] + [20:10]) mod 2048 and writes its low 16 bits to register [1:0].
- R11: Opcode 4 with count N in [15:0] puts N extra stall cycles between its own fetch and the next fetch. The gap between those two fetches is 3+N cycles.
- R12: Opcode 11 stops the core and raises `halted`. Every other opcode not listed above only advances the PC. The PC wraps from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start pulse, taken only while idle |
| start_addr | input | 11 | Program entry address |
| halted | output | 1 | Core is idle |
| mem_addr | output | 11 | Word address for fetch, load or store |
| mem_rd | output | 1 | Read request; data is returned the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 32 | Store word |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |

## Verification
Two events can land in the same clock edge: a new `run` pulse and the execution of a halt instruction. The bench starts a one-instruction halt program and counts the cycles of the fetch and the latch. It then raises `run` with a different start address exactly during the execute cycle. The core is judged correct if it ends up idle and stays idle, and if the second address is never fetched. A related case pulses `run` in the middle of a long stall. That pulse must leave the running program's stored results and fetch trace unchanged.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

    localparam logic [3:0] OP_DELAY  = 4'd4;
    localparam logic [3:0] OP_STORE  = 4'd6;
    localparam logic [3:0] OP_ALU    = 4'd7;
    localparam logic [3:0] OP_BRANCH = 4'd8;
    localparam logic [3:0] OP_HALT   = 4'd11;
    localparam logic [3:0] OP_LOAD   = 4'd13;

    localparam logic [2:0] ALU_FORM_REG   = 3'd0;
    localparam logic [2:0] ALU_FORM_IMM   = 3'd1;
    localparam logic [2:0] ALU_FORM_STAGE = 3'd2;

    localparam logic [2:0] BR_ABS   = 3'd0;
    localparam logic [2:0] BR_R0    = 3'd1;
    localparam logic [2:0] BR_STAGE = 3'd2;

    localparam logic [3:0] FN_ADD = 4'd0;
    localparam logic [3:0] FN_SUB = 4'd1;
    localparam logic [3:0] FN_AND = 4'd2;
    localparam logic [3:0] FN_OR  = 4'd3;
    localparam logic [3:0] FN_MOV = 4'd4;
    localparam logic [3:0] FN_SHL = 4'd5;
    localparam logic [3:0] FN_SHR = 4'd6;

    localparam logic [3:0] STG_INC = 4'd0;
    localparam logic [3:0] STG_DEC = 4'd1;
    localparam logic [3:0] STG_CLR = 4'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_LDWAIT,
        ST_DELAY
    } core_state_t;

endpackage

// File: rtl/mc16_alu.sv
module mc16_alu import mc16_pkg::*; #(
    parameter int W = 16
) (
    input  logic [3:0]   fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         carry,
    output logic         valid
);
    localparam int SHW = $clog2(W);

    logic [W:0] ext;

    always_comb begin
        ext   = '0;
        y     = '0;
        carry = 1'b0;
        valid = 1'b1;
        case (fn)
            FN_ADD: begin
                ext   = {1'b0, a} + {1'b0, b};
                y     = ext[W-1:0];
                carry = ext[W];
            end
            FN_SUB: begin
                ext   = {1'b0, a} - {1'b0, b};
                y     = ext[W-1:0];
                carry = ext[W];
            end
            FN_AND: y = a & b;
            FN_OR:  y = a | b;
            FN_MOV: y = b;
            FN_SHL: y = (b >= W) ? '0 : (a << b[SHW-1:0]);
            FN_SHR: y = (b >= W) ? '0 : (a >> b[SHW-1:0]);
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/mc16_branch.sv
module mc16_branch import mc16_pkg::*; #(
    parameter int PC_W    = 11,
    parameter int W       = 16,
    parameter int STAGE_W = 8
) (
    input  logic [31:0]        insn,
    input  logic [PC_W-1:0]    pc,
    input  logic [W-1:0]       r0,
    input  logic [W-1:0]       reg_target,
    input  logic               zf,
    input  logic               ovf,
    input  logic [STAGE_W-1:0] stage,
    output logic               taken,
    output logic [PC_W-1:0]    target
);
    logic [PC_W-1:0]    rel_mag;
    logic [PC_W-1:0]    rel_dest;
    logic [W-1:0]       r0_imm;
    logic [STAGE_W-1:0] stg_imm;

    assign rel_mag  = PC_W'(insn[23:17]);
    assign rel_dest = insn[24] ? (pc - rel_mag) : (pc + rel_mag);
    assign r0_imm   = W'(insn[15:0]);
    assign stg_imm  = STAGE_W'(insn[7:0]);

    always_comb begin
        taken  = 1'b0;
        target = rel_dest;
        case (insn[27:25])
            BR_ABS: begin
                target = insn[21] ? reg_target[PC_W-1:0] : PC_W'(insn[12:2]);
                case (insn[24:22])
                    3'd0:    taken = 1'b1;
                    3'd1:    taken = zf;
                    3'd2:    taken = ovf;
                    default: taken = 1'b0;
                endcase
            end
            BR_R0:
                taken = insn[16] ? (r0 >= r0_imm) : (r0 < r0_imm);
            BR_STAGE: begin
                case (insn[16:15])
                    2'd0:    taken = stage <  stg_imm;
                    2'd1:    taken = stage >= stg_imm;
                    2'd2:    taken = stage <= stg_imm;
                    default: taken = 1'b0;
                endcase
            end
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
    parameter int W    = 16,
    parameter int NREG = 4,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_c,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_c,
    output logic [W-1:0]  r0
);
    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == AW'(g))
                regs[g] <= wdata;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];
    assign r0   = regs[0];
endmodule

// File: rtl/mc16_core.sv
module mc16_core import mc16_pkg::*; #(
    parameter int PC_W    = 11,
    parameter int DATA_W  = 16,
    parameter int STAGE_W = 8,
    parameter int NREG    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PC_W-1:0] start_addr,
    output logic            halted,
    output logic [PC_W-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata
);
    localparam int RAW   = $clog2(NREG);
    localparam int DLY_W = 16;

    core_state_t state, nstate;

    logic [PC_W-1:0]    pc_q;
    logic [31:0]        ir_q;
    logic               zf_q, of_q;
    logic [STAGE_W-1:0] stage_q;
    logic [DLY_W-1:0]   dcnt_q;

    logic [3:0]  op;
    logic [2:0]  form;
    logic [3:0]  fn;
    logic [DLY_W-1:0] dly_cnt;
    assign op      = ir_q[31:28];
    assign form    = ir_q[27:25];
    assign fn      = ir_q[24:21];
    assign dly_cnt = ir_q[15:0];

    logic [DATA_W-1:0] rs_val, rt_val, rd_val, r0_val;
    logic              rf_we;
    logic [DATA_W-1:0] rf_wdata;

    mc16_regfile #(.W(DATA_W), .NREG(NREG), .AW(RAW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (RAW'(ir_q[1:0])),
        .wdata (rf_wdata),
        .ra_a  (RAW'(ir_q[3:2])),
        .ra_b  (RAW'(ir_q[5:4])),
        .ra_c  (RAW'(ir_q[1:0])),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .rd_c  (rd_val),
        .r0    (r0_val)
    );

    logic [DATA_W-1:0] alu_b, alu_y;
    logic              alu_c, alu_ok;

    always_comb begin
        if (form == ALU_FORM_IMM)
            alu_b = DATA_W'(ir_q[19:4]);
        else if (fn == FN_MOV)
            alu_b = rs_val;
        else
            alu_b = rt_val;
    end

    mc16_alu #(.W(DATA_W)) u_alu (
        .fn    (fn),
        .a     (rs_val),
        .b     (alu_b),
        .y     (alu_y),
        .carry (alu_c),
        .valid (alu_ok)
    );

    logic            br_taken;
    logic [PC_W-1:0] br_target;

    mc16_branch #(.PC_W(PC_W), .W(DATA_W), .STAGE_W(STAGE_W)) u_br (
        .insn       (ir_q),
        .pc         (pc_q),
        .r0         (r0_val),
        .reg_target (rd_val),
        .zf         (zf_q),
        .ovf        (of_q),
        .stage      (stage_q),
        .taken      (br_taken),
        .target     (br_target)
    );

    logic            alu_rf_op;
    logic [PC_W-1:0] eff_addr;
    logic [DATA_W-1:0] eff_sum;

    assign alu_rf_op = (op == OP_ALU) && alu_ok &&
                       (form == ALU_FORM_REG || form == ALU_FORM_IMM);
    assign eff_sum   = rs_val + DATA_W'(ir_q[20:10]);
    assign eff_addr  = eff_sum[PC_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   nstate = run ? ST_FETCH : ST_IDLE;
            ST_FETCH:  nstate = ST_LATCH;
            ST_LATCH:  nstate = ST_EXEC;
            ST_EXEC: begin
                if (op == OP_HALT)
                    nstate = ST_IDLE;
                else if (op == OP_LOAD)
                    nstate = ST_LDWAIT;
                else if (op == OP_DELAY && dly_cnt != '0)
                    nstate = ST_DELAY;
                else
                    nstate = ST_FETCH;
            end
            ST_LDWAIT: nstate = ST_FETCH;
            ST_DELAY:  nstate = (dcnt_q == DLY_W'(1)) ? ST_FETCH : ST_DELAY;
            default:   nstate = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        halted    = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = {11'(pc_q), 3'b000, ir_q[3:2], 16'(rd_val)};
        rf_we     = 1'b0;
        rf_wdata  = alu_y;
        unique case (state)
            ST_IDLE:  halted = 1'b1;
            ST_FETCH: mem_rd = 1'b1;
            ST_LATCH: ;
            ST_EXEC: begin
                mem_addr = eff_addr;
                mem_rd   = (op == OP_LOAD);
                mem_wr   = (op == OP_STORE);
                rf_we    = alu_rf_op;
            end
            ST_LDWAIT: begin
                rf_we    = 1'b1;
                rf_wdata = DATA_W'(mem_rdata[15:0]);
            end
            ST_DELAY: ;
            default: halted = 1'b1;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            ir_q    <= '0;
            zf_q    <= 1'b0;
            of_q    <= 1'b0;
            stage_q <= '0;
            dcnt_q  <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (run) pc_q <= start_addr;
                ST_LATCH: ir_q <= mem_rdata;
                ST_EXEC: begin
                    if (op == OP_BRANCH && br_taken)
                        pc_q <= br_target;
                    else if (op != OP_HALT)
                        pc_q <= pc_q + PC_W'(1);
                    if (alu_rf_op) begin
                        zf_q <= (alu_y == '0);
                        of_q <= alu_c;
                    end
                    if (op == OP_ALU && form == ALU_FORM_STAGE) begin
                        case (fn)
                            STG_INC: stage_q <= stage_q + STAGE_W'(ir_q[11:4]);
                            STG_DEC: stage_q <= stage_q - STAGE_W'(ir_q[11:4]);
                            STG_CLR: stage_q <= '0;
                            default: ;
                        endcase
                    end
                    if (op == OP_DELAY)
                        dcnt_q <= dly_cnt;
                end
                ST_DELAY: dcnt_q <= dcnt_q - DLY_W'(1);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mc16_checker.sv
module mc16_checker #(
    parameter int PC_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic [PC_W-1:0] start_addr,
    input logic            halted,
    input logic [PC_W-1:0] mem_addr,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [31:0]     mem_wdata,
    input logic [PC_W-1:0] pc
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !run) |=> halted);

    assert_run_fetches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && run) |=> (!halted && mem_rd && mem_addr == $past(start_addr)));

    assert_single_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    assert_store_packs_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata[20:18] == 3'b000 && mem_wdata[31:21] == 11'(pc)));
endmodule

bind mc16_core mc16_checker #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .start_addr (start_addr),
    .halted     (halted),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .pc         (pc_q)
);

// File: tb/sim_mc16_core.sv
module sim_mc16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [10:0] start_addr = '0;
    logic        halted, mem_rd, mem_wr;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    mc16_core u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .start_addr(start_addr),
        .halted(halted), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [2048];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    int tests = 0, fails = 0, cyc = 0;
    bit seen [2048];
    int fcyc [2048];

    always @(negedge clk) begin
        cyc++;
        if (mem_rd) begin
            seen[mem_addr] = 1'b1;
            fcyc[mem_addr] = cyc;
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: act=hung exp=halted");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] e_alu_r(int fn, int d, int s, int t);
        return {4'd7, 3'd0, 4'(fn), 15'd0, 2'(t), 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] e_alu_i(int fn, int d, int s, logic [15:0] imm);
        return {4'd7, 3'd1, 4'(fn), 1'b0, imm, 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] e_stg(int fn, logic [7:0] imm);
        return {4'd7, 3'd2, 4'(fn), 9'd0, imm, 4'd0};
    endfunction
    function automatic logic [31:0] e_bx(int typ, bit rg, logic [10:0] a, int d);
        return {4'd8, 3'd0, 3'(typ), rg, 8'd0, a, 2'(d)};
    endfunction
    function automatic logic [31:0] e_br(int off, bit cmp, logic [15:0] imm);
        return {4'd8, 3'd1, off < 0, 7'(off < 0 ? -off : off), cmp, imm};
    endfunction
    function automatic logic [31:0] e_bs(int off, int cmp, logic [7:0] imm);
        return {4'd8, 3'd2, off < 0, 7'(off < 0 ? -off : off), 2'(cmp), 7'd0, imm};
    endfunction
    function automatic logic [31:0] e_st(int d, int s, logic [10:0] off);
        return {4'd6, 3'd4, 4'd0, off, 6'd0, 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] e_ld(int d, int s, logic [10:0] off);
        return {4'd13, 7'd0, off, 6'd0, 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] e_dly(logic [15:0] n);
        return {4'd4, 12'd0, n};
    endfunction
    localparam logic [31:0] HALT = {4'd11, 28'd0};
    localparam logic [31:0] NOP  = {4'd10, 28'd0};

    // store register k to address 1024+k using k itself as the base
    function automatic logic [31:0] e_self(int k, logic [15:0] v);
        return e_st(k, k, 11'(1024 + k - int'(v)));
    endfunction
    function automatic logic [31:0] x_self(int pc, int k, logic [15:0] v);
        return {11'(pc), 3'b000, 2'(k), v};
    endfunction

    function automatic logic [16:0] m_alu(int fn, logic [15:0] a, logic [15:0] b);
        case (fn)
            0: return {1'b0, a} + {1'b0, b};
            1: return {1'b0, a} - {1'b0, b};
            2: return {1'b0, a & b};
            3: return {1'b0, a | b};
            4: return {1'b0, b};
            5: return (b >= 16) ? 17'd0 : {1'b0, 16'(a << b)};
            6: return (b >= 16) ? 17'd0 : {1'b0, 16'(a >> b)};
            default: return 17'd0;
        endcase
    endfunction

    task automatic kick(input logic [10:0] sa);
        for (int i = 0; i < 2048; i++) seen[i] = 1'b0;
        @(negedge clk);
        start_addr = sa;
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
    endtask

    task automatic wait_halt();
        while (!halted) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 2048; i++) mem[i] = NOP;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset halted", 32'(halted), 32'd1);
        chk("R1 reset quiet", {30'd0, mem_rd, mem_wr}, 32'd0);

        // R3/R4: random ALU sequences, flags observed through R6 branches
        for (int it = 0; it < 40; it++) begin
            logic [15:0] rm [4];
            bit zf, of;
            int p;
            for (int k = 0; k < 4; k++) begin
                rm[k] = 16'($urandom);
                mem[k] = e_alu_i(4, k, 0, rm[k]);
                zf = (rm[k] == 0); of = 1'b0;
            end
            for (int j = 0; j < 6; j++) begin
                int fn = $urandom_range(0, 6);
                int d = $urandom_range(0, 3), s = $urandom_range(0, 3), t = $urandom_range(0, 3);
                bit im = $urandom_range(0, 1);
                logic [15:0] iv = (fn >= 5) ? 16'($urandom_range(0, 20)) : 16'($urandom);
                logic [15:0] b;
                logic [16:0] r;
                if (j == 5 && it % 4 == 0) begin fn = 1; im = 1; iv = rm[s]; end
                b = im ? iv : (fn == 4 ? rm[s] : rm[t]);
                r = m_alu(fn, rm[s], b);
                mem[4 + j] = im ? e_alu_i(fn, d, s, iv) : e_alu_r(fn, d, s, t);
                rm[d] = r[15:0]; zf = (r[15:0] == 0); of = r[16];
            end
            p = 10;
            mem[p]     = e_bx(1, 1'b0, 11'(p + 2), 0);
            mem[p + 1] = NOP;
            mem[p + 2] = e_bx(2, 1'b0, 11'(p + 4), 0);
            mem[p + 3] = NOP;
            for (int k = 0; k < 4; k++) begin
                mem[p + 4 + k] = e_self(k, rm[k]);
                mem[1024 + k] = 32'hDEAD_BEEF;
            end
            mem[p + 8] = HALT;
            kick(11'd0);
            wait_halt();
            for (int k = 0; k < 4; k++)
                chk("R3 alu result", mem[1024 + k], x_self(p + 4 + k, k, rm[k]));
            chk("R4 zero flag", 32'(seen[p + 1]), 32'(!zf));
            chk("R4 overflow flag", 32'(seen[p + 3]), 32'(!of));
        end

        // R5/R8 stage counter, and stage ops leave flags alone (R4)
        mem[400] = e_alu_i(4, 0, 0, 16'd0);
        mem[401] = e_stg(2, 8'd0);
        mem[402] = e_stg(0, 8'd5);
        mem[403] = e_bs(2, 0, 8'd6);
        mem[404] = NOP;
        mem[405] = e_stg(1, 8'd2);
        mem[406] = e_bs(2, 1, 8'd4);
        mem[407] = NOP;
        mem[408] = e_bs(2, 2, 8'd3);
        mem[409] = NOP;
        mem[410] = e_stg(1, 8'd10);
        mem[411] = e_bs(2, 1, 8'd200);
        mem[412] = NOP;
        mem[413] = e_bx(1, 1'b0, 11'd415, 0);
        mem[414] = NOP;
        mem[415] = HALT;
        kick(11'd400);
        wait_halt();
        chk("R8 stage lt taken", 32'(seen[404]), 32'd0);
        chk("R8 stage ge not taken", 32'(seen[407]), 32'd1);
        chk("R8 stage le taken", 32'(seen[409]), 32'd0);
        chk("R5 stage wrap ge", 32'(seen[412]), 32'd0);
        chk("R4 stage keeps zero flag", 32'(seen[414]), 32'd0);

        // R7 relative on r0: backward loop and forward tests
        mem[300] = e_alu_i(4, 0, 0, 16'd0);
        mem[301] = e_alu_i(0, 0, 0, 16'd1);
        mem[302] = e_br(-1, 1'b0, 16'd5);
        mem[303] = e_self(0, 16'd5);
        mem[304] = e_alu_i(4, 0, 0, 16'd100);
        mem[305] = e_br(2, 1'b1, 16'd100);
        mem[306] = NOP;
        mem[307] = e_br(2, 1'b0, 16'd100);
        mem[308] = e_br(2, 1'b0, 16'd101);
        mem[309] = NOP;
        mem[310] = HALT;
        kick(11'd300);
        wait_halt();
        chk("R7 backward loop", mem[1024], x_self(303, 0, 16'd5));
        chk("R7 ge taken", 32'(seen[306]), 32'd0);
        chk("R7 lt not taken", 32'(seen[308]), 32'd1);
        chk("R7 lt taken", 32'(seen[309]), 32'd0);

        // R6 absolute branch via register
        mem[100] = e_alu_i(4, 2, 0, 16'd130);
        mem[101] = e_bx(0, 1'b1, 11'd0, 2);
        mem[102] = HALT;
        mem[130] = e_self(2, 16'd130);
        mem[131] = HALT;
        kick(11'd100);
        wait_halt();
        chk("R6 reg target skip", 32'(seen[102]), 32'd0);
        chk("R6 reg target store", mem[1026], x_self(130, 2, 16'd130));

        // R10 load keeps low 16 bits
        mem[1500] = 32'hABCD_1234;
        mem[200] = e_alu_i(4, 1, 0, 16'd1490);
        mem[201] = e_ld(3, 1, 11'd10);
        mem[202] = e_self(3, 16'h1234);
        mem[203] = HALT;
        kick(11'd200);
        wait_halt();
        chk("R10 load low half", mem[1027], x_self(202, 3, 16'h1234));

        // R11 delay timing
        foreach (fcyc[i]) fcyc[i] = 0;
        for (int n = 0; n < 3; n++) begin
            int nv = (n == 0) ? 0 : (n == 1 ? 5 : 37);
            mem[600] = e_dly(16'(nv));
            mem[601] = HALT;
            kick(11'd600);
            wait_halt();
            chk("R11 delay gap", 32'(fcyc[601] - fcyc[600]), 32'(3 + nv));
        end

        // R2 run during a stall is ignored
        mem[500] = HALT;
        mem[700] = e_alu_i(4, 1, 0, 16'h0055);
        mem[701] = e_dly(16'd40);
        mem[702] = e_self(1, 16'h0055);
        mem[703] = HALT;
        kick(11'd700);
        repeat (10) @(negedge clk);
        start_addr = 11'd500; run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        wait_halt();
        chk("R2 run ignored when busy", 32'(seen[500]), 32'd0);
        chk("R2 program completes", mem[1025], x_self(702, 1, 16'h0055));

        // R2/R12 run pulse in the same cycle as halt executes
        mem[800] = HALT;
        mem[805] = HALT;
        kick(11'd800);
        @(negedge clk);
        @(negedge clk);
        start_addr = 11'd805; run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        chk("R12 halt raises halted", 32'(halted), 32'd1);
        repeat (3) @(negedge clk);
        chk("R2 collision stays idle", {31'd0, halted}, 32'd1);
        chk("R2 collision no fetch", 32'(seen[805]), 32'd0);

        // R12 unknown opcodes are no-ops, PC wraps
        mem[2045] = e_alu_i(4, 2, 0, 16'h0077);
        mem[2046] = {4'd3, 28'h0FF_FFFF};
        mem[2047] = {4'd1, 28'h123_4567};
        mem[0]    = e_self(2, 16'h0077);
        mem[1]    = HALT;
        kick(11'd2045);
        wait_halt();
        chk("R12 pc wrap", 32'(seen[0]), 32'd1);
        chk("R12 no-op keeps regs", mem[1026], x_self(0, 2, 16'h0077));
        chk("R1 idle quiet", {30'd0, mem_rd, mem_wr}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule